// File: doc/BRIEF.md
# SPI Control and Error-Flag Logic

This block holds the control bits and the status flags of a byte-wide SPI peripheral that can work as a bus master or as a slave. It sits between a simple CPU register bus and the shift engine. It sets the end-of-byte flag, the overrun flag, the write-collision flag and the mode-fault flag. It applies the ordered register-access sequences that clear each flag, and it drives the enable and master-select bits and a level interrupt request.

The CPU reaches three registers. Each access lasts one cycle with `bus_sel` high, and reads return data combinationally. Address 0 is the control register: bit 0 is the enable, bit 1 selects master mode, bit 2 is the interrupt enable, and the other bits read as zero. Address 1 is the read-only status register: bit 0 is byte done, bit 1 is write collision, bit 2 is overrun, bit 3 is mode fault, and the other bits read as zero. Address 2 is the data register: a read returns the held receive byte and a write sends a byte to the shift engine.

Bytes move on two one-cycle streams, and neither has back-pressure. `rx_valid` is always accepted. `tx_valid` is a single-cycle pulse that is raised only when the engine is idle and the peripheral is enabled, so the engine never needs to stall it.

Top module: `spi_flag_ctrl`

## Requirements
- R1: After reset, all control bits read as zero, the status register reads 0x00, and `irq`, `spi_en` and `spi_master` are low.
- R2: While master mode (control bit 1) is set, a low level on `ss_n` at a clock edge sets mode fault (status bit 3) and clears the enable and master bits on that same edge. When master mode is clear, mode fault never sets.
- R3: While mode fault is set, control writes cannot set the enable or master bits, although the interrupt enable is still written. A status read that sees mode fault set, followed by a control write as the very next access, clears mode fault and loads all bits of that write.
- R4: Any other bus access between the first and second step of a clearing sequence cancels that sequence, and the second step then clears nothing.
- R5: An `rx_valid` pulse while byte done is clear stores `rx_data` and sets byte done (status bit 0). A status read followed by a data read as the next access clears byte done.
- R6: An `rx_valid` pulse while byte done is set sets overrun (status bit 2) and discards the new byte. The data register keeps returning the first byte received since byte done was last cleared.
- R7: A status read returns overrun as set and clears it on the same access.
- R8: A data write while `xfer_busy` is high sets write collision (status bit 1) and produces no `tx_valid`. A data write while idle and enabled raises `tx_valid` with `tx_data` equal to the written byte during that access. A data write while disabled produces no `tx_valid`.
- R9: Write collision is cleared only by a status read followed by a data read. A data write does not clear it, and it never raises `irq`.
- R10: `irq` is high exactly when the interrupt enable is set and at least one of byte done, mode fault or overrun is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe, one access per high cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 control, 1 status, 2 data |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational |
| ss_n | input | 1 | Slave-select pin level, active low |
| xfer_busy | input | 1 | Shift engine is moving a byte |
| rx_valid | input | 1 | One-cycle strobe: a received byte is complete |
| rx_data | input | DATA_W | Received byte |
| tx_valid | output | 1 | Byte handed to the shift engine this cycle |
| tx_data | output | DATA_W | Byte for the shift engine |
| spi_en | output | 1 | Peripheral enable |
| spi_master | output | 1 | Master mode select |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default 8-bit data width. At this width, distinct byte patterns such as 0x11, 0x22 and 0x33 show which received byte the overrun rule keeps. The status and control bits also land at fixed positions that the bench can compare as whole bytes. Separate scenarios each move the two clearing sequences through their armed, completed and cancelled paths. They also place mode-fault detection against slave mode and against locked control writes.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2
  } reg_sel_e;

  // control register bit positions
  localparam int unsigned CB_EN  = 0;
  localparam int unsigned CB_MST = 1;
  localparam int unsigned CB_IE  = 2;

  // status register bit positions
  localparam int unsigned SB_DONE = 0;
  localparam int unsigned SB_WCOL = 1;
  localparam int unsigned SB_OVR  = 2;
  localparam int unsigned SB_MODF = 3;
  localparam int unsigned STAT_BITS = 4;
endpackage

// File: rtl/spi_clr_seq.sv
// Two-step clearing sequence: a first-step access arms it and records which
// flags were set at that moment. The very next access either completes it
// (second step) or cancels it.
module spi_clr_seq #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         acc,
  input  logic         step1,
  input  logic         step2,
  input  logic [W-1:0] mask_in,
  output logic         fire,
  output logic [W-1:0] fire_mask
);
  logic         armed_q;
  logic [W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      mask_q  <= '0;
    end else if (acc) begin
      armed_q <= step1 && (|mask_in);
      mask_q  <= mask_in;
    end
  end

  assign fire      = acc && step2 && armed_q;
  assign fire_mask = mask_q;

  AST_SEQ_ABANDON: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !step1) |=> !armed_q); // R4
endmodule

// File: rtl/spi_rx_hold.sv
// Receive buffer with the byte-done and overrun flags.
module spi_rx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              done_clr,
  input  logic              ovr_clr,
  output logic              done,
  output logic              ovr,
  output logic [DATA_W-1:0] buf_data
);
  logic              done_q, ovr_q;
  logic [DATA_W-1:0] buf_q;
  logic              done_eff;

  // byte-done as it stands after this cycle's clear
  assign done_eff = done_q && !done_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
      buf_q  <= '0;
    end else begin
      done_q <= done_eff;
      if (ovr_clr) ovr_q <= 1'b0;
      if (rx_valid) begin
        if (done_eff) begin
          ovr_q <= 1'b1;
        end else begin
          buf_q  <= rx_data;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done     = done_q;
  assign ovr      = ovr_q;
  assign buf_data = buf_q;

  AST_BUF_KEPT_ON_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && done_q && !done_clr) |=> $stable(buf_q)); // R6
  AST_OVR_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(done_q)); // R6
endmodule

// File: rtl/spi_mode_ctrl.sv
// Enable, master and interrupt-enable bits plus mode-fault detection/lock.
module spi_mode_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr,
  input  logic en_w,
  input  logic mst_w,
  input  logic ie_w,
  input  logic ss_n,
  input  logic fault_clr,
  output logic en,
  output logic mst,
  output logic ie,
  output logic modf
);
  logic en_q, mst_q, ie_q, modf_q;
  logic fault_hit;

  assign fault_hit = mst_q && !ss_n && !modf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mst_q  <= 1'b0;
      ie_q   <= 1'b0;
      modf_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        ie_q <= ie_w;
        if (!modf_q || fault_clr) begin
          en_q  <= en_w;
          mst_q <= mst_w;
        end
        if (fault_clr) modf_q <= 1'b0;
      end
      if (fault_hit) begin
        modf_q <= 1'b1;
        en_q   <= 1'b0;
        mst_q  <= 1'b0;
      end
    end
  end

  assign en   = en_q;
  assign mst  = mst_q;
  assign ie   = ie_q;
  assign modf = modf_q;

  AST_FAULT_DROPS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(modf_q) |-> (!en_q && !mst_q)); // R2
  AST_NO_FAULT_IN_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mst_q && !modf_q) |=> !modf_q); // R2
  AST_LOCK_WHILE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    modf_q |-> (!en_q && !mst_q)); // R3
endmodule

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl
  import spi_flag_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ss_n,
  input  logic              xfer_busy,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              spi_en,
  output logic              spi_master,
  output logic              irq
);
  localparam int unsigned RD_SEQ_W = 2; // {wcol, done}

  logic rd_ctrl, wr_ctrl, rd_stat, rd_data, wr_data;
  assign rd_ctrl = bus_sel && !bus_wr && (bus_addr == REG_CTRL);
  assign wr_ctrl = bus_sel &&  bus_wr && (bus_addr == REG_CTRL);
  assign rd_stat = bus_sel && !bus_wr && (bus_addr == REG_STAT);
  assign rd_data = bus_sel && !bus_wr && (bus_addr == REG_DATA);
  assign wr_data = bus_sel &&  bus_wr && (bus_addr == REG_DATA);

  logic en, mst, ie, modf, done, ovr, wcol_q;
  logic [DATA_W-1:0] buf_data;

  // data-side sequence: status read then data read clears done / wcol
  logic                rd_fire;
  logic [RD_SEQ_W-1:0] rd_mask;
  spi_clr_seq #(.W(RD_SEQ_W)) u_rd_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc      (bus_sel),
    .step1    (rd_stat),
    .step2    (rd_data),
    .mask_in  ({wcol_q, done}),
    .fire     (rd_fire),
    .fire_mask(rd_mask)
  );

  // fault sequence: status read then control write clears mode fault
  logic       mf_fire;
  logic [0:0] mf_mask;
  spi_clr_seq #(.W(1)) u_mf_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc      (bus_sel),
    .step1    (rd_stat),
    .step2    (wr_ctrl),
    .mask_in  (modf),
    .fire     (mf_fire),
    .fire_mask(mf_mask)
  );

  spi_mode_ctrl u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_wr  (wr_ctrl),
    .en_w     (bus_wdata[CB_EN]),
    .mst_w    (bus_wdata[CB_MST]),
    .ie_w     (bus_wdata[CB_IE]),
    .ss_n     (ss_n),
    .fault_clr(mf_fire && mf_mask[0]),
    .en       (en),
    .mst      (mst),
    .ie       (ie),
    .modf     (modf)
  );

  spi_rx_hold #(.DATA_W(DATA_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_valid(rx_valid),
    .rx_data (rx_data),
    .done_clr(rd_fire && rd_mask[0]),
    .ovr_clr (rd_stat),
    .done    (done),
    .ovr     (ovr),
    .buf_data(buf_data)
  );

  // write collision flag
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcol_q <= 1'b0;
    end else if (wr_data && xfer_busy) begin
      wcol_q <= 1'b1;
    end else if (rd_fire && rd_mask[1]) begin
      wcol_q <= 1'b0;
    end
  end

  // transmit stream: one-cycle pulse, no back-pressure
  assign tx_valid = wr_data && !xfer_busy && en;
  assign tx_data  = bus_wdata;

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      REG_CTRL: begin
        bus_rdata[CB_EN]  = en;
        bus_rdata[CB_MST] = mst;
        bus_rdata[CB_IE]  = ie;
      end
      REG_STAT: begin
        bus_rdata[SB_DONE] = done;
        bus_rdata[SB_WCOL] = wcol_q;
        bus_rdata[SB_OVR]  = ovr;
        bus_rdata[SB_MODF] = modf;
      end
      REG_DATA: bus_rdata = buf_data;
      default:  bus_rdata = '0;
    endcase
  end

  assign irq        = ie && (done || modf || ovr);
  assign spi_en     = en;
  assign spi_master = mst;

  AST_WCOL_NO_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && xfer_busy) |-> !tx_valid); // R8
  AST_WCOL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && xfer_busy) |=> wcol_q); // R8
  AST_WCOL_KEPT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wcol_q && wr_data) |=> wcol_q); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |-> !irq); // R10
endmodule

// File: tb/tb_spi_flag_ctrl.sv
module tb_spi_flag_ctrl;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]    bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          ss_n = 1'b1, xfer_busy = 1'b0, rx_valid = 1'b0;
  logic [DW-1:0] rx_data = '0;
  logic          tx_valid, spi_en, spi_master, irq;
  logic [DW-1:0] tx_data;

  int n_run = 0, n_fail = 0;
  logic          s_txv;
  logic [DW-1:0] s_txd;

  always #4 clk = ~clk;

  spi_flag_ctrl #(.DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ss_n(ss_n), .xfer_busy(xfer_busy), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .spi_en(spi_en),
    .spi_master(spi_master), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [1:0] a,
                        input logic [DW-1:0] d, output logic [DW-1:0] r);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    #1;
    r = bus_rdata; s_txv = tx_valid; s_txd = tx_data;
    @(posedge clk);
    #1 bus_sel = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] r);
    access(1'b0, a, '0, r);
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    logic [DW-1:0] dummy;
    access(1'b1, a, d, dummy);
  endtask

  task automatic rx_byte(input logic [DW-1:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    @(posedge clk); #1 rx_valid = 1'b0;
  endtask

  task automatic ss_pulse();
    @(negedge clk); ss_n = 1'b0;
    @(posedge clk); #1 ss_n = 1'b1;
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [DW-1:0] r;
    do_reset();
    rd(2'd0, r); check("R1 ctrl", r, 8'h00);
    rd(2'd1, r); check("R1 status", r, 8'h00);
    settle();
    check("R1 irq/en/master", {irq, spi_en, spi_master}, 3'b000);
  endtask

  task automatic t_done();
    logic [DW-1:0] r;
    wr(2'd0, 8'h04);
    rx_byte(8'hA5);
    settle(); check("R10 irq on done", irq, 1);
    rd(2'd1, r); check("R5 done set", r, 8'h01);
    rd(2'd2, r); check("R5 data", r, 8'hA5);
    rd(2'd1, r); check("R5 done cleared", r, 8'h00);
    settle(); check("R10 irq drops", irq, 0);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_overrun();
    logic [DW-1:0] r;
    rx_byte(8'h11); rx_byte(8'h22); rx_byte(8'h33);
    rd(2'd1, r); check("R6 ovr+done", r, 8'h05);
    rd(2'd1, r); check("R7 ovr cleared by status read", r, 8'h01);
    rd(2'd2, r); check("R6 first byte kept", r, 8'h11);
    rd(2'd1, r); check("R5 all clear", r, 8'h00);
  endtask

  task automatic t_wcol();
    logic [DW-1:0] r;
    wr(2'd0, 8'h05);
    xfer_busy = 1'b1;
    access(1'b1, 2'd2, 8'h5A, r);
    check("R8 no tx when busy", s_txv, 0);
    rd(2'd1, r); check("R8 wcol set", r, 8'h02);
    settle(); check("R9 wcol no irq", irq, 0);
    access(1'b1, 2'd2, 8'h5B, r);
    rd(2'd1, r); check("R9 data write keeps wcol", r, 8'h02);
    rd(2'd2, r);
    rd(2'd1, r); check("R9 wcol cleared", r, 8'h00);
    xfer_busy = 1'b0;
    access(1'b1, 2'd2, 8'hC3, r);
    check("R8 tx pulse", {s_txv, s_txd}, {1'b1, 8'hC3});
    wr(2'd0, 8'h00);
    access(1'b1, 2'd2, 8'h77, r);
    check("R8 no tx when disabled", s_txv, 0);
  endtask

  task automatic t_modf();
    logic [DW-1:0] r;
    wr(2'd0, 8'h01);
    ss_pulse();
    rd(2'd1, r); check("R2 no fault in slave", r, 8'h00);
    wr(2'd0, 8'h07);
    ss_pulse();
    settle(); check("R2 en/master dropped", {spi_en, spi_master, irq}, 3'b001);
    rd(2'd1, r); check("R2 modf set", r, 8'h08);
    rd(2'd0, r); check("R2 ctrl after fault", r, 8'h04);
    wr(2'd0, 8'h07);
    rd(2'd0, r); check("R3 locked write", r, 8'h04);
    rd(2'd1, r);
    rd(2'd2, r);
    wr(2'd0, 8'h03);
    rd(2'd0, r); check("R4 abandoned fault clear", r, 8'h00);
    rd(2'd1, r); check("R4 modf still set", r, 8'h08);
    wr(2'd0, 8'h03);
    rd(2'd0, r); check("R3 clear write loads bits", r, 8'h03);
    rd(2'd1, r); check("R3 modf cleared", r, 8'h00);
    settle(); check("R10 irq low", irq, 0);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_abandon_rd();
    logic [DW-1:0] r;
    rx_byte(8'h9C);
    rd(2'd1, r);
    rd(2'd0, r);
    rd(2'd2, r); check("R5 data readable", r, 8'h9C);
    rd(2'd1, r); check("R4 done survives abandoned seq", r, 8'h01);
    rd(2'd2, r);
    rd(2'd1, r); check("R5 done cleared after proper seq", r, 8'h00);
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_done();
    t_overrun();
    t_wcol();
    t_modf();
    t_abandon_rd();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule